// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block decides whether the address byte that follows a START condition on an I2C bus is meant for this slave. A bit-level front end captures the eight bits: seven address bits in positions 7 to 1 and the read/write bit in position 0. It hands them over with a one-cycle valid strobe. The recognizer compares the seven address bits with a programmed primary address. It answers with a one-cycle match pulse, a sticky address-event flag, and a direction flag that records the read/write bit of the last accepted byte.

A second 7-bit configuration word has two roles, chosen by a select input. With the select low, the word is a per-bit don't-care mask on the primary compare. With the select high, it is a second complete address, and either address is accepted. A promiscuous enable accepts every address byte. For 10-bit addressing, the primary address is programmed as `11110` followed by address bits 9 and 8. The block then recognises the header byte through the ordinary compare, and the host resolves the low address byte that follows.

Top module: `slave_addr_recognizer`

## Requirements
- R1: With promiscuous off and the select low, a strobed byte matches when `addr_byte[7:1]` equals `cfg_primary[6:0]` bit for bit, wherever `cfg_second` holds zeros. `addr_byte[0]` never takes part in the compare.
- R2: With promiscuous off and the select low, each 1 in `cfg_second[i]` makes address bit i+1 a don't-care, so that bit always matches.
- R3: With promiscuous off and the select high, a byte matches when `addr_byte[7:1]` equals `cfg_primary` or equals `cfg_second`. No bit is masked in this mode.
- R4: With promiscuous on, every strobed byte matches, whatever the primary address, the second word and the select hold.
- R5: With `cfg_primary` = `11110` followed by bits 9:8 of a 10-bit address, a header byte `11110`, those two bits, and either R/W value matches. A header that carries other values for bits 9:8 does not match.
- R6: `match_pulse` is high for exactly the one cycle after a clock edge that samples `addr_valid` high together with a match. It is low after every other edge.
- R7: `addr_flag` goes to 1 at the edge that samples a match and stays at 1 until an edge samples `flag_clear` high. If a match and `flag_clear` are sampled at the same edge, the flag is set.
- R8: At the edge that samples a match, `dir_flag` takes the value of `addr_byte[0]` (1 = master read, 0 = master write). At any other edge it holds its value.
- R9: While `rst_n` is low, `match_pulse`, `addr_flag` and `dir_flag` are 0.
- R10: A strobed byte that does not match produces no pulse and leaves `addr_flag` and `dir_flag` unchanged. An unstrobed cycle does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_valid | input | 1 | One-cycle strobe: `addr_byte` holds a captured address byte |
| addr_byte | input | 8 | Address bits in [7:1], R/W bit in [0] |
| cfg_primary | input | 7 | Primary slave address |
| cfg_second | input | 7 | Don't-care mask (select low) or second address (select high) |
| cfg_dual_sel | input | 1 | 0 = second word is a mask, 1 = second word is an address |
| cfg_promisc | input | 1 | 1 = accept every address byte |
| flag_clear | input | 1 | Host clear of `addr_flag` |
| match_pulse | output | 1 | One-cycle pulse on an accepted address byte |
| addr_flag | output | 1 | Sticky address-event flag |
| dir_flag | output | 1 | R/W bit of the last accepted byte |

## Verification
A wrong compare shows at `match_pulse` one clock after the strobe. The same edge makes `addr_flag` rise or fail to rise, and makes `dir_flag` take or miss the R/W bit. The flags are sticky, so a spurious set stays visible after the pulse has gone: a wrong flag persists until the next clear, and a wrong direction persists until the next accepted byte. Each step of the bench therefore compares all three outputs with the model. This catches both the immediate pulse error and the lasting flag corruption.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int unsigned SAR_ADDR_BITS = 7;

  typedef enum logic [1:0] {
    MODE_MASKED = 2'd0,
    MODE_DUAL   = 2'd1,
    MODE_ANY    = 2'd2
  } sar_mode_e;

  // promiscuous overrides the select bit
  function automatic sar_mode_e sar_pick_mode(input logic promisc, input logic dual_sel);
    if (promisc)       return MODE_ANY;
    else if (dual_sel) return MODE_DUAL;
    else               return MODE_MASKED;
  endfunction

endpackage

// File: rtl/sar_cmp_bank.sv
module sar_cmp_bank #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] rx_addr,
  input  logic [W-1:0] ref_a,
  input  logic [W-1:0] ref_b,
  output logic [W-1:0] diff_a,
  output logic [W-1:0] diff_b
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff_a[i] = rx_addr[i] ^ ref_a[i];
    assign diff_b[i] = rx_addr[i] ^ ref_b[i];
  end

endmodule

// File: rtl/sar_decide.sv
module sar_decide #(
  parameter int unsigned W = 7
) (
  input  sar_pkg::sar_mode_e mode,
  input  logic [W-1:0]       diff_a,
  input  logic [W-1:0]       diff_b,
  input  logic [W-1:0]       second_word,
  output logic               addr_hit
);
  import sar_pkg::*;

  logic masked_ok;
  logic a_ok;
  logic b_ok;

  assign masked_ok = ~|(diff_a & ~second_word);
  assign a_ok      = ~|diff_a;
  assign b_ok      = ~|diff_b;

  always_comb begin
    unique case (mode)
      MODE_ANY:    addr_hit = 1'b1;
      MODE_DUAL:   addr_hit = a_ok | b_ok;
      MODE_MASKED: addr_hit = masked_ok;
      default:     addr_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/sar_event_regs.sv
module sar_event_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_evt,
  input  logic rw_bit,
  input  logic clr,
  output logic pulse_q,
  output logic flag_q,
  output logic dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      pulse_q <= hit_evt;
      if (hit_evt)  flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (hit_evt)  dir_q  <= rw_bit;
    end
  end

endmodule

// File: rtl/slave_addr_recognizer.sv
module slave_addr_recognizer #(
  parameter int unsigned ADDR_W = sar_pkg::SAR_ADDR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  input  logic [ADDR_W:0]   addr_byte,
  input  logic [ADDR_W-1:0] cfg_primary,
  input  logic [ADDR_W-1:0] cfg_second,
  input  logic              cfg_dual_sel,
  input  logic              cfg_promisc,
  input  logic              flag_clear,
  output logic              match_pulse,
  output logic              addr_flag,
  output logic              dir_flag
);
  import sar_pkg::*;

  logic [ADDR_W-1:0] rx_addr;
  logic              rw_bit;
  logic [ADDR_W-1:0] diff_pri;
  logic [ADDR_W-1:0] diff_sec;
  sar_mode_e         mode;
  logic              addr_hit;
  logic              hit_evt;

  assign rx_addr = addr_byte[ADDR_W:1];
  assign rw_bit  = addr_byte[0];
  assign mode    = sar_pick_mode(cfg_promisc, cfg_dual_sel);

  sar_cmp_bank #(.W(ADDR_W)) u_cmp (
    .rx_addr (rx_addr),
    .ref_a   (cfg_primary),
    .ref_b   (cfg_second),
    .diff_a  (diff_pri),
    .diff_b  (diff_sec)
  );

  sar_decide #(.W(ADDR_W)) u_dec (
    .mode        (mode),
    .diff_a      (diff_pri),
    .diff_b      (diff_sec),
    .second_word (cfg_second),
    .addr_hit    (addr_hit)
  );

  assign hit_evt = addr_valid & addr_hit;

  sar_event_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_evt (hit_evt),
    .rw_bit  (rw_bit),
    .clr     (flag_clear),
    .pulse_q (match_pulse),
    .flag_q  (addr_flag),
    .dir_q   (dir_flag)
  );

endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter int unsigned ADDR_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            addr_valid,
  input logic [ADDR_W:0] addr_byte,
  input logic            cfg_promisc,
  input logic            flag_clear,
  input logic            hit_evt,
  input logic            match_pulse,
  input logic            addr_flag,
  input logic            dir_flag
);

  assert_no_pulse_without_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> !match_pulse);

  assert_pulse_follows_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> match_pulse);

  assert_promisc_accepts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && cfg_promisc) |=> match_pulse);

  assert_flag_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> addr_flag);

  assert_flag_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clear && !hit_evt) |=> !addr_flag);

  assert_flag_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clear && !hit_evt) |=> $stable(addr_flag));

  assert_dir_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (dir_flag == $past(addr_byte[0])));

  assert_dir_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_evt |=> $stable(dir_flag));

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (!match_pulse && !addr_flag && !dir_flag);
    end
  end

endmodule

bind slave_addr_recognizer sar_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_valid  (addr_valid),
  .addr_byte   (addr_byte),
  .cfg_promisc (cfg_promisc),
  .flag_clear  (flag_clear),
  .hit_evt     (hit_evt),
  .match_pulse (match_pulse),
  .addr_flag   (addr_flag),
  .dir_flag    (dir_flag)
);

// File: tb/sim_slave_addr_recognizer.sv
`timescale 1ns/1ps
module sim_slave_addr_recognizer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_valid = 1'b0;
  logic [7:0] addr_byte = '0;
  logic [6:0] cfg_primary = '0;
  logic [6:0] cfg_second = '0;
  logic       cfg_dual_sel = 1'b0;
  logic       cfg_promisc = 1'b0;
  logic       flag_clear = 1'b0;
  logic       match_pulse, addr_flag, dir_flag;

  int tests = 0;
  int fails = 0;
  bit exp_flag = 0;
  bit exp_dir = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  slave_addr_recognizer u0 (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_byte(addr_byte),
    .cfg_primary(cfg_primary), .cfg_second(cfg_second), .cfg_dual_sel(cfg_dual_sel),
    .cfg_promisc(cfg_promisc), .flag_clear(flag_clear),
    .match_pulse(match_pulse), .addr_flag(addr_flag), .dir_flag(dir_flag)
  );

  // bench model: walk the bits and tally mismatches
  function automatic bit ref_accept(bit [7:0] b, bit [6:0] p, bit [6:0] s, bit dual, bit prom);
    int miss_p = 0;
    int miss_s = 0;
    if (prom) return 1'b1;
    for (int i = 0; i < 7; i++) begin
      if (b[i+1] != p[i] && (dual || !s[i])) miss_p++;
      if (b[i+1] != s[i]) miss_s++;
    end
    if (dual) return (miss_p == 0) || (miss_s == 0);
    return miss_p == 0;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // called at a negedge: drive, update model, check at the following negedge
  task automatic step(string tag, bit v, bit [7:0] b, bit [6:0] p, bit [6:0] s,
                      bit dual, bit prom, bit clr);
    bit hit;
    addr_valid = v; addr_byte = b; cfg_primary = p; cfg_second = s;
    cfg_dual_sel = dual; cfg_promisc = prom; flag_clear = clr;
    hit = v && ref_accept(b, p, s, dual, prom);
    if (hit) begin
      exp_flag = 1'b1;
      exp_dir  = b[0];
    end else if (clr) begin
      exp_flag = 1'b0;
    end
    @(negedge clk);
    chk({tag, " pulse"}, match_pulse, hit);
    chk("R7 flag", addr_flag, exp_flag);
    chk("R8 dir", dir_flag, exp_dir);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit [6:0] p, s, flip;
    bit [7:0] b;
    bit dual, prom, v, clr;
    string tag;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 pulse", match_pulse, 1'b0);
    chk("R9 flag", addr_flag, 1'b0);
    chk("R9 dir", dir_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 exact hit with read, R/W bit excluded
    step("R1", 1, {7'h2A, 1'b1}, 7'h2A, 7'h00, 0, 0, 0);
    // R6 pulse lasts one cycle
    step("R6", 0, {7'h2A, 1'b1}, 7'h2A, 7'h00, 0, 0, 0);
    // R10 non-matching byte: flag and dir untouched
    step("R10", 1, {7'h2B, 1'b0}, 7'h2A, 7'h00, 0, 0, 0);
    chk("R10 flag kept", addr_flag, 1'b1);
    chk("R10 dir kept", dir_flag, 1'b1);
    // R7 clear, then simultaneous set and clear
    step("R7", 0, 8'h00, 7'h2A, 7'h00, 0, 0, 1);
    step("R7", 1, {7'h2A, 1'b0}, 7'h2A, 7'h00, 0, 0, 1);
    // R2 masked low bits
    step("R2", 1, {7'h2D, 1'b1}, 7'h2A, 7'h07, 0, 0, 0);
    step("R2", 1, {7'h6A, 1'b0}, 7'h2A, 7'h07, 0, 0, 0);
    // R3 second address, and mask not applied in dual mode
    step("R3", 1, {7'h51, 1'b0}, 7'h2A, 7'h51, 1, 0, 0);
    step("R3", 1, {7'h2B, 1'b1}, 7'h2A, 7'h01, 1, 0, 0);
    // R4 promiscuous
    step("R4", 1, {7'h13, 1'b1}, 7'h2A, 7'h00, 0, 1, 0);
    // R5 10-bit header 11110 + bits 9:8 = 10
    step("R5", 1, {7'b1111010, 1'b0}, 7'b1111010, 7'h00, 0, 0, 0);
    step("R5", 1, {7'b1111011, 1'b1}, 7'b1111010, 7'h00, 0, 0, 0);

    for (int n = 0; n < 600; n++) begin
      p    = 7'($urandom);
      s    = 7'($urandom);
      dual = $urandom_range(1, 0) == 1;
      prom = $urandom_range(7, 0) == 0;
      v    = $urandom_range(3, 0) != 0;
      clr  = $urandom_range(3, 0) == 0;
      flip = 7'($urandom & $urandom & $urandom);
      b[7:1] = (dual && $urandom_range(1, 0) == 1) ? s : p;
      b[7:1] = b[7:1] ^ flip;
      b[0]   = 1'($urandom);
      if (!dual && flip == 0) s = s & 7'($urandom & $urandom);
      tag = prom ? "R4" : (dual ? "R3" : ((s == 0) ? "R1" : "R2"));
      step(tag, v, b, p, s, dual, prom, clr);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule